// File: doc/BRIEF.md
# Synchronous Buck Phase Gate Sequencer

This block turns a slow switching-clock tick and a handful of single-bit comparator results into the two gate-enable signals of one synchronous buck phase. It runs on a fast system clock and measures every time interval in system-clock cycles. On each tick it waits out a programmable dead time and then turns on the high-side gate. The high side stays on until the peak-current comparator trips or the maximum on-time runs out. A second dead time follows, and then the low-side gate conducts until the inductor current reaches zero or the next tick arrives.

In pulse-skip mode, a tick that finds the output above regulation starts no cycle, so the phase idles until a tick finds the output low again. A current-limit input removes the high-side gate within the same system-clock cycle. A fault input parks the phase with the low side fully on. A soft-start code climbs by one step every fixed number of ticks after enable, and the analog peak-current limit reads this code.

Top module: `buck_gate_seq`

## Requirements
- R1: After a tick is sampled at edge E, both gates are off after edges E to E+D-1, and the high side is on after edge E+D. Here D is the dead-time input, counted in system clocks. The high side never turns on in the cycle directly after the low side was on.
- R2: When the high side ends, both gates stay off for D cycles before the low side turns on, unless the fault input forced the low side.
- R3: The low side turns off at the first edge that samples either the zero-current input or a tick. If zero current is sampled at the edge that ends the dead time, the low side does not turn on in that cycle.
- R4: The high side ends at the edge that samples the peak-current input high. Without a peak trip it lasts exactly MAX_ON cycles, and it is never on for more than MAX_ON consecutive cycles.
- R5: While the current-limit input is high, the high-side output is low in that same cycle. The phase then proceeds to the low-side dead time.
- R6: With skip mode high, a tick that samples the output-above-regulation input high turns both gates off and starts no cycle. With skip mode low, that input has no effect.
- R7: While the fault input is high, the low-side gate is on and the high-side gate is off from the next edge onward. Ticks and the enable input do not change this.
- R8: The high-side and low-side outputs are never high in the same cycle.
- R9: While enable is low and the fault input is low, both gates are off and the soft-start code is 0 from the next edge onward. Both gates and the code are 0 after reset.
- R10: While enabled, the 8-bit soft-start code rises by one at every SS_DIV-th tick and holds at 255. It never rises by more than one per cycle.
- R11: A dead-time input of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Phase enable |
| force_low | input | 1 | Fault override: low side on, high side off |
| sw_tick | input | 1 | One-cycle pulse at each switching-clock rising edge |
| skip_mode | input | 1 | 1 selects light-load pulse skipping, 0 full-rate PWM |
| out_high | input | 1 | Output is above regulation |
| pk_trip | input | 1 | Peak-current comparator tripped |
| ilim_trip | input | 1 | Current-limit comparator tripped |
| zero_cur | input | 1 | Inductor current has reached zero |
| dead_cyc | input | DT_W | Dead time in system-clock cycles |
| hs_on | output | 1 | High-side gate enable |
| ls_on | output | 1 | Low-side gate enable |
| ss_code | output | SS_W | Soft-start peak-current code |

## Verification
Every gate change is registered, so an input sampled at edge E shows on the outputs right after edge E. The high side appears after edge E+D following a tick. The one path that does not wait for an edge is the current-limit gating of the high side, which is checked a moment after the input rises, before the next edge. The bench changes inputs and samples outputs on the falling edge. For each switching period it records which edge produced each output value. It then compares the first edge and the length of each gate's on interval against figures derived from D, MAX_ON and the edge at which each comparator pulse was applied.

// File: rtl/buck_seq_pkg.sv
package buck_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_DEAD_HI = 3'd1,
        PH_HIGH    = 3'd2,
        PH_DEAD_LO = 3'd3,
        PH_LOW     = 3'd4
    } phase_e;

endpackage

// File: rtl/buck_phase_fsm.sv
module buck_phase_fsm
    import buck_seq_pkg::*;
#(
    parameter int DT_W   = 4,
    parameter int MAX_ON = 316
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            force_low,
    input  logic            sw_tick,
    input  logic            skip_mode,
    input  logic            out_high,
    input  logic            pk_trip,
    input  logic            ilim_trip,
    input  logic            zero_cur,
    input  logic [DT_W-1:0] dead_cyc,
    output logic            hs_q_o,
    output logic            ls_q_o
);
    localparam int ON_W  = $clog2(MAX_ON + 1);
    localparam int CNT_W = (ON_W > DT_W) ? ON_W : DT_W;
    localparam logic [CNT_W-1:0] ON_LAST = CNT_W'(MAX_ON - 1);

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic             hs;
        logic             ls;
    } fsm_t;

    fsm_t r_d, r_q;

    logic [DT_W-1:0]  dt_eff;
    logic [CNT_W-1:0] dt_last;

    always_comb begin
        dt_eff  = (dead_cyc == '0) ? DT_W'(1) : dead_cyc;
        dt_last = CNT_W'(dt_eff) - CNT_W'(1);

        r_d     = r_q;
        r_d.cnt = r_q.cnt + CNT_W'(1);

        if (!en || force_low) begin
            r_d.ph  = PH_IDLE;
            r_d.cnt = '0;
        end else if (sw_tick) begin
            r_d.cnt = '0;
            if (skip_mode && out_high) begin
                r_d.ph = PH_IDLE;
            end else begin
                r_d.ph = PH_DEAD_HI;
            end
        end else begin
            case (r_q.ph)
                PH_DEAD_HI: begin
                    if (ilim_trip) begin
                        r_d.ph  = PH_IDLE;
                        r_d.cnt = '0;
                    end else if (r_q.cnt == dt_last) begin
                        r_d.ph  = PH_HIGH;
                        r_d.cnt = '0;
                    end
                end
                PH_HIGH: begin
                    if (ilim_trip || pk_trip || (r_q.cnt == ON_LAST)) begin
                        r_d.ph  = PH_DEAD_LO;
                        r_d.cnt = '0;
                    end
                end
                PH_DEAD_LO: begin
                    if (r_q.cnt == dt_last) begin
                        r_d.ph  = zero_cur ? PH_IDLE : PH_LOW;
                        r_d.cnt = '0;
                    end
                end
                PH_LOW: begin
                    r_d.cnt = r_q.cnt;
                    if (zero_cur) begin
                        r_d.ph = PH_IDLE;
                    end
                end
                default: begin
                    r_d.ph  = PH_IDLE;
                    r_d.cnt = r_q.cnt;
                end
            endcase
        end

        r_d.hs = (r_d.ph == PH_HIGH) && !force_low;
        r_d.ls = (r_d.ph == PH_LOW) || force_low;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{ph: PH_IDLE, cnt: '0, hs: 1'b0, ls: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign hs_q_o = r_q.hs;
    assign ls_q_o = r_q.ls;

endmodule

// File: rtl/buck_softstart.sv
module buck_softstart #(
    parameter int SS_W   = 8,
    parameter int SS_DIV = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            sw_tick,
    output logic [SS_W-1:0] code_o
);
    localparam int TCNT_W = (SS_DIV > 1) ? $clog2(SS_DIV) : 1;
    localparam logic [TCNT_W-1:0] TCNT_LAST = TCNT_W'(SS_DIV - 1);
    localparam logic [SS_W-1:0]   CODE_TOP  = '1;

    typedef struct packed {
        logic [TCNT_W-1:0] tcnt;
        logic [SS_W-1:0]   code;
    } ss_t;

    ss_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!en) begin
            s_d.tcnt = '0;
            s_d.code = '0;
        end else if (sw_tick) begin
            if (s_q.tcnt == TCNT_LAST) begin
                s_d.tcnt = '0;
                if (s_q.code != CODE_TOP) begin
                    s_d.code = s_q.code + SS_W'(1);
                end
            end else begin
                s_d.tcnt = s_q.tcnt + TCNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{tcnt: '0, code: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign code_o = s_q.code;

endmodule

// File: rtl/buck_gate_seq.sv
module buck_gate_seq #(
    parameter int DT_W   = 4,
    parameter int MAX_ON = 316,
    parameter int SS_W   = 8,
    parameter int SS_DIV = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            force_low,
    input  logic            sw_tick,
    input  logic            skip_mode,
    input  logic            out_high,
    input  logic            pk_trip,
    input  logic            ilim_trip,
    input  logic            zero_cur,
    input  logic [DT_W-1:0] dead_cyc,
    output logic            hs_on,
    output logic            ls_on,
    output logic [SS_W-1:0] ss_code
);
    logic hs_q;
    logic ls_q;

    buck_phase_fsm #(
        .DT_W   (DT_W),
        .MAX_ON (MAX_ON)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .force_low (force_low),
        .sw_tick   (sw_tick),
        .skip_mode (skip_mode),
        .out_high  (out_high),
        .pk_trip   (pk_trip),
        .ilim_trip (ilim_trip),
        .zero_cur  (zero_cur),
        .dead_cyc  (dead_cyc),
        .hs_q_o    (hs_q),
        .ls_q_o    (ls_q)
    );

    buck_softstart #(
        .SS_W   (SS_W),
        .SS_DIV (SS_DIV)
    ) u_ss (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .sw_tick (sw_tick),
        .code_o  (ss_code)
    );

    // current limit cuts the high side without waiting for an edge
    assign hs_on = hs_q && !ilim_trip;
    assign ls_on = ls_q;

endmodule

// File: rtl/buck_gate_seq_chk.sv
module buck_gate_seq_chk #(
    parameter int MAX_ON = 316,
    parameter int SS_W   = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            en,
    input logic            force_low,
    input logic            ilim_trip,
    input logic            hs_on,
    input logic            ls_on,
    input logic [SS_W-1:0] ss_code
);
    localparam int RUN_W = $clog2(MAX_ON + 2) + 1;

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (hs_on) begin
            run_q <= run_q + RUN_W'(1);
        end else begin
            run_q <= '0;
        end
    end

    // R8
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_on && ls_on));

    // R5
    ilim_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ilim_trip |-> !hs_on);

    // R1
    dead_before_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_on) |-> !$past(ls_on));

    // R2
    dead_before_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ls_on) && !$past(force_low)) |-> !$past(hs_on));

    // R4
    max_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_W'(MAX_ON));

    // R7
    force_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_low |=> (ls_on && !hs_on));

    // R9
    disabled_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !force_low) |=> (!hs_on && !ls_on && ss_code == '0));

    // R10
    ss_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (ss_code == $past(ss_code) || ss_code == $past(ss_code) + SS_W'(1)));

endmodule

bind buck_gate_seq buck_gate_seq_chk #(
    .MAX_ON (MAX_ON),
    .SS_W   (SS_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .force_low (force_low),
    .ilim_trip (ilim_trip),
    .hs_on     (hs_on),
    .ls_on     (ls_on),
    .ss_code   (ss_code)
);

// File: tb/sim_buck_gate_seq.sv
module sim_buck_gate_seq;
    localparam int CLK_PERIOD = 10;
    localparam int DT_W   = 4;
    localparam int MAX_ON = 12;
    localparam int SS_W   = 8;
    localparam int SS_DIV = 2;
    localparam int PER    = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, force_low = 1'b0, sw_tick = 1'b0, skip_mode = 1'b0;
    logic out_high = 1'b0, pk_trip = 1'b0, ilim_trip = 1'b0, zero_cur = 1'b0;
    logic [DT_W-1:0] dead_cyc = 4'd2;
    logic hs_on, ls_on;
    logic [SS_W-1:0] ss_code;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;
    int m_hf, m_hl, m_lf, m_ll, m_ovl;

    always #(CLK_PERIOD/2) clk = ~clk;

    buck_gate_seq #(
        .DT_W(DT_W), .MAX_ON(MAX_ON), .SS_W(SS_W), .SS_DIV(SS_DIV)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .force_low(force_low),
        .sw_tick(sw_tick), .skip_mode(skip_mode), .out_high(out_high),
        .pk_trip(pk_trip), .ilim_trip(ilim_trip), .zero_cur(zero_cur),
        .dead_cyc(dead_cyc), .hs_on(hs_on), .ls_on(ls_on), .ss_code(ss_code)
    );

    typedef struct packed {
        logic       skip;
        logic       oh;
        logic [4:0] pk;   // edge index of a peak-trip pulse, 0 = none
        logic [4:0] zc;   // edge index of a zero-current pulse, 0 = none
        logic [4:0] hf;   // first edge after which high side is on
        logic [4:0] hl;   // high-side cycles
        logic [4:0] lf;   // first edge after which low side is on
        logic [4:0] ll;   // low-side cycles
    } vec_t;

    // dead time 2, MAX_ON 12, period 20 edges
    localparam vec_t VT [8] = '{
        '{1'b0, 1'b0, 5'd0, 5'd0,  5'd2, 5'd12, 5'd16, 5'd4},
        '{1'b1, 1'b1, 5'd0, 5'd0,  5'd0, 5'd0,  5'd0,  5'd0},
        '{1'b0, 1'b1, 5'd0, 5'd0,  5'd2, 5'd12, 5'd16, 5'd4},
        '{1'b0, 1'b0, 5'd7, 5'd0,  5'd2, 5'd5,  5'd9,  5'd11},
        '{1'b0, 1'b0, 5'd5, 5'd12, 5'd2, 5'd3,  5'd7,  5'd5},
        '{1'b1, 1'b0, 5'd0, 5'd0,  5'd2, 5'd12, 5'd16, 5'd4},
        '{1'b0, 1'b0, 5'd0, 5'd16, 5'd2, 5'd12, 5'd0,  5'd0},
        '{1'b1, 1'b0, 5'd9, 5'd0,  5'd2, 5'd7,  5'd11, 5'd9}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic rec(input int i);
        if (hs_on) begin
            if (m_hl == 0) m_hf = i;
            m_hl++;
        end
        if (ls_on) begin
            if (m_ll == 0) m_lf = i;
            m_ll++;
        end
        if (hs_on && ls_on) m_ovl++;
    endtask

    task automatic run_period(input logic skip, input logic oh, input int pk_at, input int zc_at);
        m_hf = 0; m_hl = 0; m_lf = 0; m_ll = 0; m_ovl = 0;
        for (int k = 0; k < PER; k++) begin
            @(negedge clk);
            if (k > 0) rec(k - 1);
            sw_tick   = (k == 0);
            skip_mode = skip;
            out_high  = oh;
            pk_trip   = (pk_at != 0) && (k == pk_at);
            zero_cur  = (zc_at != 0) && (k == zc_at);
        end
        @(negedge clk);
        rec(PER - 1);
        sw_tick = 1'b0; pk_trip = 1'b0; zero_cur = 1'b0; out_high = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk(!hs_on, "R9 reset hs", hs_on, 0);
        chk(!ls_on, "R9 reset ls", ls_on, 0);
        chk(ss_code == 0, "R9 reset ss", ss_code, 0);
        en = 1'b1;

        // table walk: R1 R2 R3 R4 R6 R8
        foreach (VT[v]) begin
            run_period(VT[v].skip, VT[v].oh, int'(VT[v].pk), int'(VT[v].zc));
            chk(m_hf == int'(VT[v].hf), "R1 high start", m_hf, VT[v].hf);
            chk(m_hl == int'(VT[v].hl), "R4 high length", m_hl, VT[v].hl);
            chk(m_lf == int'(VT[v].lf), "R2 low start", m_lf, VT[v].lf);
            chk(m_ll == int'(VT[v].ll), "R3/R6 low length", m_ll, VT[v].ll);
            chk(m_ovl == 0, "R8 overlap", m_ovl, 0);
        end

        // R5: current limit mid high side
        @(negedge clk); sw_tick = 1'b1;
        @(negedge clk); sw_tick = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(hs_on, "R1 high after dead time", hs_on, 1);
        @(negedge clk);
        ilim_trip = 1'b1;
        #1;
        chk(!hs_on, "R5 same-cycle cut", hs_on, 0);
        @(negedge clk); ilim_trip = 1'b0;
        chk(!hs_on && !ls_on, "R5 dead after limit", ls_on, 0);
        @(negedge clk);
        chk(!ls_on, "R2 dead second cycle", ls_on, 0);
        @(negedge clk);
        chk(ls_on, "R2 low after dead time", ls_on, 1);
        zero_cur = 1'b1;
        @(negedge clk); zero_cur = 1'b0;
        chk(!ls_on, "R3 zero current ends low", ls_on, 0);

        // R7 fault override
        force_low = 1'b1;
        @(negedge clk);
        chk(ls_on && !hs_on, "R7 forced low", ls_on, 1);
        sw_tick = 1'b1;
        @(negedge clk); sw_tick = 1'b0;
        repeat (3) @(negedge clk);
        chk(ls_on && !hs_on, "R7 tick ignored", hs_on, 0);
        en = 1'b0;
        @(negedge clk);
        chk(ls_on, "R7 held while disabled", ls_on, 1);
        force_low = 1'b0;
        @(negedge clk);
        // R9 disabled
        chk(!hs_on && !ls_on, "R9 disabled gates", ls_on, 0);
        chk(ss_code == 0, "R9 disabled ss", ss_code, 0);
        en = 1'b1;

        // R11 zero dead time
        dead_cyc = 4'd0;
        run_period(1'b0, 1'b0, 0, 0);
        chk(m_hf == 1, "R11 dead 0 as 1", m_hf, 1);
        chk(m_hl == MAX_ON, "R4 max on", m_hl, MAX_ON);
        dead_cyc = 4'd3;
        run_period(1'b0, 1'b0, 0, 0);
        chk(m_hf == 3, "R1 dead 3", m_hf, 3);
        chk(m_lf == 3 + MAX_ON + 3, "R2 dead 3", m_lf, 3 + MAX_ON + 3);
        dead_cyc = 4'd2;

        // R10 soft-start ramp
        en = 1'b0;
        @(negedge clk);
        en = 1'b1;
        for (int t = 0; t < 10; t++) begin
            @(negedge clk); sw_tick = 1'b1;
            @(negedge clk); sw_tick = 1'b0;
        end
        @(negedge clk);
        chk(ss_code == 5, "R10 ramp", ss_code, 5);
        for (int t = 0; t < 600; t++) begin
            @(negedge clk); sw_tick = 1'b1;
            @(negedge clk); sw_tick = 1'b0;
        end
        @(negedge clk);
        chk(ss_code == 255, "R10 saturate", ss_code, 255);

        finish_run();
    end

endmodule